// File: doc/BRIEF.md
# Multi-mode quadrature position counter

This block turns two encoder inputs, A and B, into a position count. It supports four counting modes. In full quadrature decoding, every edge of A or B is one count and the phase between the two inputs gives the direction. In pulse-plus-direction mode, A is the count clock and B is the direction level. The other two modes count only up or only down on A. Both inputs pass through a two-flop synchroniser, and a registered copy of the previous sample is kept for edge detection.

Software reaches the block through a small word-wide register port, where writes take effect on the clock edge and reads are combinational. That port gives access to the count, to a programmable ceiling, and to two 16-bit control words. One control word holds the mode field and an edge-select bit. The other holds the enable bit. The count wraps between zero and the ceiling. A write of a count above the ceiling is refused.

Top module: `quad_pos_counter`

## Requirements
- R1: After reset the count is 0, the ceiling is all ones, both control words are 0 (quadrature mode, counting off), and err_o is 0.
- R2: Register addresses are: 0 = count, 1 = ceiling, 2 = decoder control (16 bits), 3 = position control (16 bits). A read returns the stored value, and the upper bits of the 16-bit words read as zero.
- R3: Decoder-control bits 15:14 select the mode. When they are 0 (quadrature), each single edge of A or B counts once. With the pair written {A,B}, the order 00,10,11,01,00 counts up and the reverse order counts down.
- R4: In quadrature mode, a sample in which A and B both change produces no count. It sets err_o, which stays high until reset.
- R5: Mode 1 (pulse/direction) counts only on rising edges of A. It counts up when B is 1 and down when B is 0. Edges of B and falling edges of A do not count.
- R6: Mode 2 counts up on A. B has no effect on the count.
- R7: Mode 3 counts down on A. B has no effect on the count.
- R8: In modes 2 and 3, decoder-control bit 11 chooses the edges of A that count: when it is 0, rising edges only; when it is 1, both rising and falling edges.
- R9: Counting happens only while position-control bit 3 is 1. Edges seen while it is 0 are tracked but are never counted, including after the bit is set again.
- R10: Counting up from the ceiling gives 0. Counting down from 0 gives the ceiling.
- R11: A count write of a value above the ceiling leaves the count unchanged. A write equal to the ceiling is accepted.
- R12: An accepted count write in the same cycle as a count event loads the written value, and the event is lost.
- R13: An input edge changes the count on the third rising clock edge after the input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 1 | Encoder input A (asynchronous) |
| b_i | input | 1 | Encoder input B (asynchronous) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | CNT_W | Register write data |
| reg_rdata_o | output | CNT_W | Register read data for reg_addr_i |
| err_o | output | 1 | Sticky flag for an illegal quadrature transition |

## Verification
The bench builds the block with its default parameters: a 32-bit count and a two-stage synchroniser. With the default width, the down-wrap from zero meets the reset ceiling of all ones, so the bench's modulo-2^32 model stays exact. A ceiling of 5, written through the register port, brings both wrap directions and the accept/reject boundary within a few encoder edges. The two-stage synchroniser fixes the three-edge latency, which the bench checks edge by edge. It also uses that latency to line up a count event with a software write in the same cycle.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
  localparam int CTRL_W      = 16;
  localparam int MODE_HI     = 15;
  localparam int MODE_LO     = 14;
  localparam int BOTH_BIT    = 11;
  localparam int EN_BIT      = 3;
  localparam int IDX_A       = 0;
  localparam int IDX_B       = 1;

  typedef enum logic [1:0] {
    MODE_QUAD = 2'd0,
    MODE_PDIR = 2'd1,
    MODE_UP   = 2'd2,
    MODE_DOWN = 2'd3
  } qpc_mode_e;

  typedef enum logic [1:0] {
    ADDR_CNT = 2'd0,
    ADDR_MAX = 2'd1,
    ADDR_DEC = 2'd2,
    ADDR_POS = 2'd3
  } qpc_addr_e;
endpackage

// File: rtl/qpc_sync.sv
module qpc_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] q_prev_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[g] <= '0;
        else         stg_q[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[g] <= '0;
        else         stg_q[g] <= stg_q[g-1];
    end
  end

  // previous sample always tracked, independent of enable
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q_prev_o <= '0;
    else         q_prev_o <= stg_q[STAGES-1];

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/qpc_decode.sv
module qpc_decode
  import qpc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic [1:0] cur_i,
  input  logic [1:0] prev_i,
  input  qpc_mode_e mode_i,
  input  logic      both_i,
  input  logic      en_i,
  output logic      evt_o,
  output logic      up_o,
  output logic      err_o
);
  logic [1:0] chg;
  logic       a_rise, raw, illegal;

  assign chg    = cur_i ^ prev_i;
  assign a_rise = cur_i[IDX_A] & ~prev_i[IDX_A];

  always_comb begin
    raw     = 1'b0;
    up_o    = 1'b1;
    illegal = 1'b0;
    unique case (mode_i)
      MODE_QUAD: begin
        raw     = ^chg;
        illegal = &chg;
        up_o    = cur_i[IDX_A] ^ prev_i[IDX_B];
      end
      MODE_PDIR: begin
        raw  = a_rise;
        up_o = cur_i[IDX_B];
      end
      MODE_UP: begin
        raw  = both_i ? chg[IDX_A] : a_rise;
        up_o = 1'b1;
      end
      MODE_DOWN: begin
        raw  = both_i ? chg[IDX_A] : a_rise;
        up_o = 1'b0;
      end
      default: ;
    endcase
  end

  assign evt_o = raw & en_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)              err_o <= 1'b0;
    else if (illegal && en_i) err_o <= 1'b1;

  assert_illegal_no_count_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_QUAD && &chg) |-> !evt_o);
  assert_err_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  assert_up_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && mode_i == MODE_UP) |-> up_o);
  assert_down_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && mode_i == MODE_DOWN) |-> !up_o);
endmodule

// File: rtl/qpc_counter.sv
module qpc_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic             up_i,
  input  logic [CNT_W-1:0] max_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic wr_ok;
  assign wr_ok = wr_i && (wdata_i <= max_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    cnt_o <= '0;
    else if (wr_ok) cnt_o <= wdata_i;
    else if (evt_i) begin
      if (up_i) cnt_o <= (cnt_o >= max_i) ? '0 : cnt_o + 1'b1;
      else      cnt_o <= (cnt_o == '0) ? max_i : cnt_o - 1'b1;
    end

  assert_wr_wins_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i <= max_i) |=> cnt_o == $past(wdata_i));
  assert_wr_reject_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i > max_i && !evt_i) |=> $stable(cnt_o));
  assert_wrap_up_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && up_i && !wr_i && cnt_o == max_i) |=> cnt_o == '0);
  assert_wrap_dn_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && !up_i && !wr_i && cnt_o == '0) |=> cnt_o == $past(max_i));
endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter
  import qpc_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             a_i,
  input  logic             b_i,
  input  logic             reg_wr_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [CNT_W-1:0] reg_wdata_i,
  output logic [CNT_W-1:0] reg_rdata_o,
  output logic             err_o
);
  logic [CNT_W-1:0]  max_q, cnt;
  logic [CTRL_W-1:0] dec_q, pos_q;
  logic [1:0]        cur, prev;
  logic              evt, up, wr_cnt;

  assign wr_cnt = reg_wr_i && (reg_addr_i == ADDR_CNT);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      max_q <= '1;
      dec_q <= '0;
      pos_q <= '0;
    end else if (reg_wr_i) begin
      unique case (qpc_addr_e'(reg_addr_i))
        ADDR_MAX: max_q <= reg_wdata_i;
        ADDR_DEC: dec_q <= reg_wdata_i[CTRL_W-1:0];
        ADDR_POS: pos_q <= reg_wdata_i[CTRL_W-1:0];
        default: ;
      endcase
    end

  always_comb begin
    unique case (qpc_addr_e'(reg_addr_i))
      ADDR_CNT: reg_rdata_o = cnt;
      ADDR_MAX: reg_rdata_o = max_q;
      ADDR_DEC: reg_rdata_o = CNT_W'(dec_q);
      ADDR_POS: reg_rdata_o = CNT_W'(pos_q);
      default:  reg_rdata_o = '0;
    endcase
  end

  qpc_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .d_i      ({b_i, a_i}),
    .q_o      (cur),
    .q_prev_o (prev)
  );

  qpc_decode u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cur_i  (cur),
    .prev_i (prev),
    .mode_i (qpc_mode_e'(dec_q[MODE_HI:MODE_LO])),
    .both_i (dec_q[BOTH_BIT]),
    .en_i   (pos_q[EN_BIT]),
    .evt_o  (evt),
    .up_o   (up),
    .err_o  (err_o)
  );

  qpc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt),
    .up_i    (up),
    .max_i   (max_q),
    .wr_i    (wr_cnt),
    .wdata_i (reg_wdata_i),
    .cnt_o   (cnt)
  );

  assert_disabled_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pos_q[EN_BIT] && !wr_cnt) |=> $stable(cnt));
  assert_b_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_q[MODE_HI] && !wr_cnt && cur[IDX_A] == prev[IDX_A]) |=> $stable(cnt));
endmodule

// File: tb/quad_pos_counter_tb_top.sv
module quad_pos_counter_tb_top;
  localparam int CNT_W = 32;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             a_i = 1'b0, b_i = 1'b0;
  logic             reg_wr_i = 1'b0;
  logic [1:0]       reg_addr_i = 2'd0;
  logic [CNT_W-1:0] reg_wdata_i = '0;
  logic [CNT_W-1:0] reg_rdata_o;
  logic             err_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [CNT_W-1:0] exp_cnt = '0;

  always #5 clk = ~clk;

  quad_pos_counter #(.CNT_W(CNT_W)) dut_i (
    .clk_i (clk), .rst_ni (rst_ni), .a_i (a_i), .b_i (b_i),
    .reg_wr_i (reg_wr_i), .reg_addr_i (reg_addr_i),
    .reg_wdata_i (reg_wdata_i), .reg_rdata_o (reg_rdata_o), .err_o (err_o)
  );

  task automatic chk(string req, logic [CNT_W-1:0] act, logic [CNT_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] addr, logic [CNT_W-1:0] d);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_addr_i = addr; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(logic [1:0] addr, output logic [CNT_W-1:0] d);
    reg_addr_i = addr;
    #1 d = reg_rdata_o;
  endtask

  task automatic chk_cnt(string req);
    logic [CNT_W-1:0] v;
    rd(2'd0, v);
    chk(req, v, exp_cnt);
  endtask

  task automatic set_ab(logic a, logic b);
    @(negedge clk);
    a_i = a; b_i = b;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [CNT_W-1:0] v;
    rd(2'd0, v); chk("R1 count", v, '0);
    rd(2'd1, v); chk("R1 ceiling", v, '1);
    rd(2'd2, v); chk("R1 dec ctl", v, '0);
    rd(2'd3, v); chk("R1 pos ctl", v, '0);
    chk("R1 err", {31'd0, err_o}, '0);
  endtask

  task automatic t_regs;
    logic [CNT_W-1:0] v;
    wr(2'd1, 32'h1234_5678); rd(2'd1, v); chk("R2 ceiling rw", v, 32'h1234_5678);
    wr(2'd2, 32'hFFFF_C800); rd(2'd2, v); chk("R2 dec 16b", v, 32'h0000_C800);
    wr(2'd3, 32'hABCD_0004); rd(2'd3, v); chk("R2 pos 16b", v, 32'h0000_0004);
    wr(2'd0, 32'd7); exp_cnt = 7; chk_cnt("R2 count rw");
    wr(2'd1, '1); wr(2'd2, 0); wr(2'd3, 0); wr(2'd0, 0); exp_cnt = 0;
  endtask

  task automatic t_quad;
    wr(2'd2, 32'h0000); wr(2'd3, 32'h8);
    set_ab(1, 0); exp_cnt++; chk_cnt("R3 fwd 00-10");
    set_ab(1, 1); exp_cnt++; chk_cnt("R3 fwd 10-11");
    set_ab(0, 1); exp_cnt++; chk_cnt("R3 fwd 11-01");
    set_ab(0, 0); exp_cnt++; chk_cnt("R3 fwd 01-00");
    set_ab(0, 1); exp_cnt--; chk_cnt("R3 rev 00-01");
    set_ab(1, 1); exp_cnt--; chk_cnt("R3 rev 01-11");
    set_ab(1, 0); exp_cnt--; chk_cnt("R3 rev 11-10");
    set_ab(0, 0); exp_cnt--; chk_cnt("R3 rev 10-00");
    set_ab(0, 1); exp_cnt--; chk_cnt("R3 below zero");
    set_ab(0, 0); exp_cnt++; chk_cnt("R3 back to zero");
  endtask

  task automatic t_illegal;
    chk("R4 err clear before", {31'd0, err_o}, '0);
    set_ab(1, 1); chk_cnt("R4 double change no count");
    chk("R4 err set", {31'd0, err_o}, 32'd1);
    set_ab(0, 1); exp_cnt++; chk_cnt("R4 legal after illegal");
    set_ab(0, 0); exp_cnt++; chk_cnt("R4 legal step");
    chk("R4 err sticky", {31'd0, err_o}, 32'd1);
  endtask

  task automatic t_pdir;
    wr(2'd2, 32'h4000);
    set_ab(0, 1); chk_cnt("R5 B edge no count");
    set_ab(1, 1); exp_cnt++; chk_cnt("R5 A rise B high up");
    set_ab(0, 1); chk_cnt("R5 A fall no count");
    set_ab(0, 0); chk_cnt("R5 B fall no count");
    set_ab(1, 0); exp_cnt--; chk_cnt("R5 A rise B low down");
    set_ab(0, 0);
  endtask

  task automatic t_updown;
    wr(2'd2, 32'h8000);
    set_ab(1, 0); exp_cnt++; chk_cnt("R6 up on rise");
    set_ab(0, 0); chk_cnt("R8 rising only, fall ignored");
    set_ab(0, 1); chk_cnt("R6 B ignored");
    set_ab(1, 0); exp_cnt++; chk_cnt("R6 up with B change");
    set_ab(0, 0);
    wr(2'd2, 32'hC000);
    set_ab(1, 1); exp_cnt--; chk_cnt("R7 down on rise");
    set_ab(1, 0); chk_cnt("R7 B ignored");
    set_ab(0, 0); chk_cnt("R7 fall ignored");
  endtask

  task automatic t_both;
    wr(2'd2, 32'h8800);
    set_ab(1, 0); exp_cnt++; chk_cnt("R8 up rise");
    set_ab(0, 0); exp_cnt++; chk_cnt("R8 up fall");
    wr(2'd2, 32'hC800);
    set_ab(1, 0); exp_cnt--; chk_cnt("R8 down rise");
    set_ab(0, 0); exp_cnt--; chk_cnt("R8 down fall");
  endtask

  task automatic t_enable;
    wr(2'd2, 32'h8000); wr(2'd3, 32'h0);
    set_ab(1, 0); set_ab(0, 0); set_ab(1, 0);
    chk_cnt("R9 disabled no count");
    wr(2'd3, 32'h8); repeat (4) @(negedge clk);
    chk_cnt("R9 no spurious count on enable");
    set_ab(0, 0); set_ab(1, 0); exp_cnt++; chk_cnt("R9 counts after enable");
    set_ab(0, 0);
  endtask

  task automatic t_wrap;
    wr(2'd1, 32'd5); wr(2'd0, 32'd5); exp_cnt = 5; chk_cnt("R11 write equal ceiling");
    wr(2'd0, 32'd9); chk_cnt("R11 write above ceiling ignored");
    wr(2'd2, 32'h8000);
    set_ab(1, 0); exp_cnt = 0; chk_cnt("R10 up wrap to 0");
    wr(2'd2, 32'hC000);
    set_ab(0, 0); set_ab(1, 0); exp_cnt = 5; chk_cnt("R10 down wrap to ceiling");
    set_ab(0, 0);
    wr(2'd1, '1);
  endtask

  task automatic t_latency;
    wr(2'd2, 32'h8000); wr(2'd0, 32'd20); exp_cnt = 20;
    @(negedge clk); a_i = 1'b1;
    @(negedge clk); chk_cnt("R13 no change after edge 1");
    @(negedge clk); chk_cnt("R13 no change after edge 2");
    @(negedge clk); exp_cnt++; chk_cnt("R13 change after edge 3");
    set_ab(0, 0);
  endtask

  task automatic t_priority;
    wr(2'd2, 32'h8000);
    @(negedge clk); a_i = 1'b1;
    @(negedge clk); @(negedge clk);
    reg_wr_i = 1'b1; reg_addr_i = 2'd0; reg_wdata_i = 32'd100;
    @(negedge clk); reg_wr_i = 1'b0;
    exp_cnt = 100; chk_cnt("R12 write wins");
    repeat (4) @(negedge clk); chk_cnt("R12 event not replayed");
    set_ab(0, 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset;
    t_regs;
    t_quad;
    t_illegal;
    t_pdir;
    t_updown;
    t_both;
    t_enable;
    t_wrap;
    t_latency;
    t_priority;
    finish_run;
  end

  initial begin
    #(200_000 * 10);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    finish_run;
  end
endmodule